// File: doc/BRIEF.md
# Opcode-Keyed Fault Rule Table

This block keeps a small table of fault-injection rules for a message-oriented serial link. A rule is keyed by an 8-bit message opcode, or by a wildcard that matches any opcode, together with a fault kind. The kind's top bit says whether the fault belongs to the receive side or the transmit side. Each rule also holds an 8-bit argument and a trigger mode. A write port installs, replaces, disables and clears rules. Each write supplies the opcode, wildcard flag, kind, mode and argument, or for a clear, a scope and an optional opcode limit.

For each message, the receive or transmit engine pulses `msg_start` with the opcode and the direction. One cycle later the block presents the set of fault kinds that fire and the argument for each kind. It holds them until the engine pulses `msg_done`. One cycle after that strobe, the block commits the mode bookkeeping. A once-rule that fired deletes itself. A toggle-rule flips its phase on every matching message.

The control FSM has three states. In S_IDLE writes are accepted, and `msg_start` moves it to S_HELD. In S_HELD the answer is presented, and `msg_done` moves it to S_COMMIT. S_COMMIT applies the mode updates and always returns to S_IDLE on the next cycle.

Top module: `frt_table`

## Requirements
- R1: A stored rule matches a message when the rule is a wildcard or its opcode equals `msg_op`, and the top bit of its 4-bit kind (1 = transmit, 0 = receive) equals `msg_tx`.
- R2: `msg_start` in S_IDLE captures `msg_op`/`msg_tx`. `res_valid` is high from the next cycle until the cycle after `msg_done`. Bit k of `res_fire` is set when a rule of kind k fires, and `res_arg[8k+7:8k]` then carries that rule's argument; both are zero for non-firing kinds and whenever `res_valid` is low.
- R3: `wr_mode` encodes 0 = once, 1 = always, 2 = toggle, 3 = off. A once-rule fires on the next matching message and is removed at that message's commit.
- R4: An always-rule fires on every matching message.
- R5: A toggle-rule fires on the first matching message after it is written. After that it alternates, flipping its phase on every matching message whether or not it fired.
- R6: A write with mode off removes the rule with the same key (opcode or wildcard, and kind); with no such rule it changes nothing.
- R7: Writing an existing key replaces its mode and argument without using a new slot. Rules with different keys coexist and fire together. When an opcode-specific rule and a wildcard rule of the same kind both fire, the argument comes from the opcode-specific rule.
- R8: A clear (`wr_clear`=1) removes rules by `wr_scope`: 0 or 3 = all, 1 = receive kinds only, 2 = transmit kinds only. With `wr_by_op`=1 it removes only rules keyed by exactly `wr_op` (wildcard rules stay).
- R9: The table holds 16 rules. Adding a new key when all slots are used is ignored and sets `tbl_full`, which any clear write resets.
- R10: Mode updates are committed in the cycle after `msg_done`, and `res_valid` is low in that cycle.
- R11: Writes presented while a message is in S_HELD or S_COMMIT are ignored.
- R12: After reset the table is empty, and `res_valid`, `res_fire` and `tbl_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_clear | input | 1 | 1 = clear command, 0 = set rule |
| wr_op | input | 8 | Rule opcode, or opcode limit for clear |
| wr_any | input | 1 | Rule matches any opcode |
| wr_kind | input | 4 | Fault kind, top bit = transmit |
| wr_mode | input | 2 | Trigger mode |
| wr_arg | input | 8 | Fault argument |
| wr_scope | input | 2 | Clear scope |
| wr_by_op | input | 1 | Limit clear to `wr_op` |
| msg_start | input | 1 | Message lookup request |
| msg_op | input | 8 | Message opcode |
| msg_tx | input | 1 | Message direction, 1 = transmit |
| msg_done | input | 1 | Engine finished with message |
| res_valid | output | 1 | Answer presented |
| res_fire | output | 16 | Firing fault kinds |
| res_arg | output | 128 | Per-kind argument, 8 bits each |
| tbl_full | output | 1 | A new rule was rejected for lack of space |

## Verification
The hardest situation to reach is a single message that hits a mix of rule states at once: an opcode-specific rule and a wildcard rule of the same kind, a toggle rule in its silent phase, and a once-rule about to vanish. Reaching it from the ports takes a history of earlier messages. Random stimulus therefore draws opcodes from a four-value pool and kinds from all sixteen, so keys collide often. It interleaves set, off and clear writes with messages in both directions, and a bench model tracks slot use, phases and arguments. Directed cases fill all sixteen slots, write during a held answer, and step toggles across several messages.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int OP_W      = 8;
    localparam int KIND_W    = 4;
    localparam int ARG_W     = 8;
    localparam int NUM_KINDS = 1 << KIND_W;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_ALWAYS = 2'd1,
        MODE_TOGGLE = 2'd2,
        MODE_OFF    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_HELD   = 2'd1,
        S_COMMIT = 2'd2
    } state_e;

    typedef struct packed {
        logic              used;
        logic              any;
        logic [OP_W-1:0]   op;
        logic [KIND_W-1:0] kind;
        mode_e             mode;
        logic [ARG_W-1:0]  arg;
        logic              phase;
    } rule_t;
endpackage

// File: rtl/frt_rule_match.sv
module frt_rule_match
    import frt_pkg::*;
(
    input  logic            r_used,
    input  logic            r_any,
    input  logic [OP_W-1:0] r_op,
    input  logic            r_dir,
    input  logic            r_toggle,
    input  logic            r_phase,
    input  logic [OP_W-1:0] q_op,
    input  logic            q_tx,
    output logic            hit,
    output logic            fire
);
    always_comb begin
        hit  = r_used && (r_any || (r_op == q_op)) && (r_dir == q_tx);
        fire = hit && (!r_toggle || r_phase);
    end
endmodule

// File: rtl/frt_slot_alloc.sv
module frt_slot_alloc
    import frt_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]             used_v,
    input  logic [NUM_SLOTS-1:0]             any_v,
    input  logic [NUM_SLOTS-1:0][OP_W-1:0]   op_v,
    input  logic [NUM_SLOTS-1:0][KIND_W-1:0] kind_v,
    input  logic                             k_any,
    input  logic [OP_W-1:0]                  k_op,
    input  logic [KIND_W-1:0]                k_kind,
    output logic                             same_found,
    output logic [IDX_W-1:0]                 same_idx,
    output logic                             free_found,
    output logic [IDX_W-1:0]                 free_idx
);
    // Descending scan: the lowest matching index is written last and wins.
    always_comb begin
        same_found = 1'b0;
        same_idx   = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (used_v[i] && (any_v[i] == k_any) && (kind_v[i] == k_kind) &&
                (k_any || (op_v[i] == k_op))) begin
                same_found = 1'b1;
                same_idx   = IDX_W'(i);
            end
            if (!used_v[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/frt_resolve.sv
module frt_resolve
    import frt_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic [NUM_SLOTS-1:0]             fire_v,
    input  logic [NUM_SLOTS-1:0]             any_v,
    input  logic [NUM_SLOTS-1:0][KIND_W-1:0] kind_v,
    input  logic [NUM_SLOTS-1:0][ARG_W-1:0]  arg_v,
    output logic [NUM_KINDS-1:0]             kind_fire,
    output logic [NUM_KINDS*ARG_W-1:0]       kind_arg
);
    // Wildcard pass first, opcode-specific pass second so it overrides.
    always_comb begin
        kind_fire = '0;
        kind_arg  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (fire_v[i] && any_v[i]) begin
                kind_fire[kind_v[i]]               = 1'b1;
                kind_arg[kind_v[i]*ARG_W +: ARG_W] = arg_v[i];
            end
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (fire_v[i] && !any_v[i]) begin
                kind_fire[kind_v[i]]               = 1'b1;
                kind_arg[kind_v[i]*ARG_W +: ARG_W] = arg_v[i];
            end
        end
    end
endmodule

// File: rtl/frt_table.sv
module frt_table
    import frt_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_clear,
    input  logic [OP_W-1:0]            wr_op,
    input  logic                       wr_any,
    input  logic [KIND_W-1:0]          wr_kind,
    input  logic [1:0]                 wr_mode,
    input  logic [ARG_W-1:0]           wr_arg,
    input  logic [1:0]                 wr_scope,
    input  logic                       wr_by_op,
    input  logic                       msg_start,
    input  logic [OP_W-1:0]            msg_op,
    input  logic                       msg_tx,
    input  logic                       msg_done,
    output logic                       res_valid,
    output logic [NUM_KINDS-1:0]       res_fire,
    output logic [NUM_KINDS*ARG_W-1:0] res_arg,
    output logic                       tbl_full
);
    state_e state_q, state_d;
    rule_t [NUM_SLOTS-1:0] tbl_q;
    logic [OP_W-1:0] lat_op;
    logic            lat_tx;

    logic [NUM_SLOTS-1:0]             used_v, any_v, hit_v, fire_v;
    logic [NUM_SLOTS-1:0][OP_W-1:0]   op_v;
    logic [NUM_SLOTS-1:0][KIND_W-1:0] kind_v;
    logic [NUM_SLOTS-1:0][ARG_W-1:0]  arg_v;
    logic                             same_found, free_found;
    logic [IDX_W-1:0]                 same_idx, free_idx;
    logic [NUM_KINDS-1:0]             raw_fire;
    logic [NUM_KINDS*ARG_W-1:0]       raw_arg;
    logic                             wr_take;
    rule_t                            new_rule;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign used_v[g] = tbl_q[g].used;
        assign any_v[g]  = tbl_q[g].any;
        assign op_v[g]   = tbl_q[g].op;
        assign kind_v[g] = tbl_q[g].kind;
        assign arg_v[g]  = tbl_q[g].arg;
        frt_rule_match u_match (
            .r_used   (tbl_q[g].used),
            .r_any    (tbl_q[g].any),
            .r_op     (tbl_q[g].op),
            .r_dir    (tbl_q[g].kind[KIND_W-1]),
            .r_toggle (tbl_q[g].mode == MODE_TOGGLE),
            .r_phase  (tbl_q[g].phase),
            .q_op     (lat_op),
            .q_tx     (lat_tx),
            .hit      (hit_v[g]),
            .fire     (fire_v[g])
        );
    end

    frt_slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .used_v     (used_v),
        .any_v      (any_v),
        .op_v       (op_v),
        .kind_v     (kind_v),
        .k_any      (wr_any),
        .k_op       (wr_op),
        .k_kind     (wr_kind),
        .same_found (same_found),
        .same_idx   (same_idx),
        .free_found (free_found),
        .free_idx   (free_idx)
    );

    frt_resolve #(.NUM_SLOTS(NUM_SLOTS)) u_resolve (
        .fire_v    (fire_v),
        .any_v     (any_v),
        .kind_v    (kind_v),
        .arg_v     (arg_v),
        .kind_fire (raw_fire),
        .kind_arg  (raw_arg)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (msg_start) state_d = S_HELD;
            S_HELD:   if (msg_done)  state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        res_valid = (state_q == S_HELD);
        res_fire  = res_valid ? raw_fire : '0;
        res_arg   = res_valid ? raw_arg  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_op <= '0;
            lat_tx <= 1'b0;
        end else if (state_q == S_IDLE && msg_start) begin
            lat_op <= msg_op;
            lat_tx <= msg_tx;
        end
    end

    assign wr_take  = wr_en && (state_q == S_IDLE);
    assign new_rule = '{used: 1'b1, any: wr_any, op: (wr_any ? '0 : wr_op),
                        kind: wr_kind, mode: mode_e'(wr_mode), arg: wr_arg,
                        phase: 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q    <= '0;
            tbl_full <= 1'b0;
        end else if (state_q == S_COMMIT) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (fire_v[i] && tbl_q[i].mode == MODE_ONCE)
                    tbl_q[i].used <= 1'b0;
                if (hit_v[i] && tbl_q[i].mode == MODE_TOGGLE)
                    tbl_q[i].phase <= ~tbl_q[i].phase;
            end
        end else if (wr_take) begin
            if (wr_clear) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (((wr_scope == 2'd1) ? !tbl_q[i].kind[KIND_W-1] :
                         (wr_scope == 2'd2) ?  tbl_q[i].kind[KIND_W-1] : 1'b1) &&
                        (!wr_by_op || (!tbl_q[i].any && tbl_q[i].op == wr_op)))
                        tbl_q[i].used <= 1'b0;
                end
                tbl_full <= 1'b0;
            end else if (mode_e'(wr_mode) == MODE_OFF) begin
                if (same_found) tbl_q[same_idx].used <= 1'b0;
            end else if (same_found) begin
                tbl_q[same_idx] <= new_rule;
            end else if (free_found) begin
                tbl_q[free_idx] <= new_rule;
            end else begin
                tbl_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frt_table_chk.sv
module frt_table_chk
    import frt_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 wr_clear,
    input logic                 msg_start,
    input logic                 msg_tx,
    input logic                 msg_done,
    input logic                 res_valid,
    input logic [NUM_KINDS-1:0] res_fire,
    input logic                 tbl_full,
    input state_e               state_q
);
    localparam int HALF = NUM_KINDS / 2;
    logic dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= 1'b0;
        else if (state_q == S_IDLE && msg_start) dir_q <= msg_tx;
    end

    AST_ANSWER_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(msg_start)); // R2
    AST_RX_ONLY_RX_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !dir_q) |-> (res_fire[NUM_KINDS-1:HALF] == '0)); // R1
    AST_TX_ONLY_TX_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && dir_q) |-> (res_fire[HALF-1:0] == '0)); // R1
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid)) |-> $stable(res_fire)); // R11
    AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && msg_done) |=> !res_valid); // R10
    AST_FULL_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbl_full) |-> $past(wr_en && !wr_clear)); // R9
endmodule

bind frt_table frt_table_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_clear  (wr_clear),
    .msg_start (msg_start),
    .msg_tx    (msg_tx),
    .msg_done  (msg_done),
    .res_valid (res_valid),
    .res_fire  (res_fire),
    .tbl_full  (tbl_full),
    .state_q   (state_q)
);

// File: tb/frt_table_tb.sv
module frt_table_tb;
    localparam int NS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 0, wr_clear = 0, wr_any = 0, wr_by_op = 0;
    logic [7:0]   wr_op = 0, wr_arg = 0;
    logic [3:0]   wr_kind = 0;
    logic [1:0]   wr_mode = 0, wr_scope = 0;
    logic         msg_start = 0, msg_tx = 0, msg_done = 0;
    logic [7:0]   msg_op = 0;
    logic         res_valid, tbl_full;
    logic [15:0]  res_fire;
    logic [127:0] res_arg;

    int checks = 0, errors = 0;

    // reference model
    bit       m_used[NS], m_any[NS], m_phase[NS];
    bit [7:0] m_op[NS], m_arg[NS];
    bit [3:0] m_kind[NS];
    bit [1:0] m_mode[NS];
    bit       m_full;

    frt_table u_dut (.*);

    always #5 clk = ~clk;

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_write(bit clr, bit [7:0] op, bit any, bit [3:0] kind,
                                        bit [1:0] mode, bit [7:0] arg, bit [1:0] scope, bit byop);
        int same = -1, free = -1;
        if (clr) begin
            for (int i = 0; i < NS; i++)
                if (((scope == 1) ? !m_kind[i][3] : (scope == 2) ? m_kind[i][3] : 1'b1) &&
                    (!byop || (!m_any[i] && m_op[i] == op)))
                    m_used[i] = 0;
            m_full = 0;
            return;
        end
        for (int i = NS - 1; i >= 0; i--) begin
            if (m_used[i] && m_any[i] == any && m_kind[i] == kind && (any || m_op[i] == op)) same = i;
            if (!m_used[i]) free = i;
        end
        if (mode == 2'd3) begin
            if (same >= 0) m_used[same] = 0;
        end else begin
            int s = (same >= 0) ? same : free;
            if (s < 0) m_full = 1;
            else begin
                m_used[s] = 1; m_any[s] = any; m_op[s] = op; m_kind[s] = kind;
                m_mode[s] = mode; m_arg[s] = arg; m_phase[s] = 1;
            end
        end
    endfunction

    function automatic bit m_hit(int i, bit [7:0] op, bit tx);
        return m_used[i] && (m_any[i] || m_op[i] == op) && (m_kind[i][3] == tx);
    endfunction

    function automatic bit m_fire(int i, bit [7:0] op, bit tx);
        return m_hit(i, op, tx) && (m_mode[i] != 2'd2 || m_phase[i]);
    endfunction

    function automatic void model_expect(bit [7:0] op, bit tx, output bit [15:0] f, output bit [127:0] a);
        f = '0; a = '0;
        for (int pass = 0; pass < 2; pass++)
            for (int i = 0; i < NS; i++)
                if (m_fire(i, op, tx) && (m_any[i] == (pass == 0))) begin
                    f[m_kind[i]] = 1'b1;
                    a[m_kind[i]*8 +: 8] = m_arg[i];
                end
    endfunction

    function automatic void model_commit(bit [7:0] op, bit tx);
        bit h[NS], fr[NS];
        for (int i = 0; i < NS; i++) begin h[i] = m_hit(i, op, tx); fr[i] = m_fire(i, op, tx); end
        for (int i = 0; i < NS; i++) begin
            if (fr[i] && m_mode[i] == 2'd0) m_used[i] = 0;
            if (h[i] && m_mode[i] == 2'd2) m_phase[i] = !m_phase[i];
        end
    endfunction

    task automatic do_write(string req, bit clr, bit [7:0] op, bit any, bit [3:0] kind,
                            bit [1:0] mode, bit [7:0] arg, bit [1:0] scope, bit byop);
        @(negedge clk);
        wr_en = 1; wr_clear = clr; wr_op = op; wr_any = any; wr_kind = kind;
        wr_mode = mode; wr_arg = arg; wr_scope = scope; wr_by_op = byop;
        @(negedge clk);
        wr_en = 0;
        model_write(clr, op, any, kind, mode, arg, scope, byop);
        check({req, " full flag"}, 128'(tbl_full), 128'(m_full));
    endtask

    task automatic do_set(string req, bit [7:0] op, bit any, bit [3:0] kind, bit [1:0] mode, bit [7:0] arg);
        do_write(req, 0, op, any, kind, mode, arg, 0, 0);
    endtask

    task automatic do_msg(string req, bit [7:0] op, bit tx, bit inject_wr);
        bit [15:0] ef; bit [127:0] ea; logic [15:0] f0;
        @(negedge clk);
        msg_start = 1; msg_op = op; msg_tx = tx;
        @(negedge clk);
        msg_start = 0;
        model_expect(op, tx, ef, ea);
        check({req, " R2 valid"}, 128'(res_valid), 128'(1));
        check({req, " fire"}, 128'(res_fire), 128'(ef));
        check({req, " arg"}, res_arg, ea);
        if (inject_wr) begin
            f0 = res_fire;
            wr_en = 1; wr_clear = 0; wr_op = 8'h77; wr_any = 0; wr_kind = 4'd1;
            wr_mode = 2'd1; wr_arg = 8'h11;
            @(negedge clk);
            wr_en = 0;
            check("R11 held stable", 128'(res_fire), 128'(f0));
        end
        msg_done = 1;
        @(negedge clk);
        msg_done = 0;
        check("R10 valid drops after done", 128'(res_valid), 128'(0));
        @(negedge clk);
        model_commit(op, tx);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [7:0] pool[4] = '{8'h00, 8'h36, 8'h82, 8'h9e};
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12 valid", 128'(res_valid), 0);
        check("R12 fire", 128'(res_fire), 0);
        check("R12 full", 128'(tbl_full), 0);
        do_msg("R12 empty table", 8'h82, 0, 0);

        // R3 once
        do_set("R3", 8'h82, 0, 4'd2, 2'd0, 8'h05);
        do_msg("R3 once fires", 8'h82, 0, 0);
        do_msg("R3 once gone", 8'h82, 0, 0);

        // R1/R4 direction and always
        do_set("R4", 8'h10, 0, 4'd9, 2'd1, 8'h44);
        do_msg("R1 wrong direction", 8'h10, 0, 0);
        do_msg("R4 always 1", 8'h10, 1, 0);
        do_msg("R4 always 2", 8'h10, 1, 0);
        do_msg("R1 other opcode", 8'h11, 1, 0);

        // R5 toggle
        do_set("R5", 8'h00, 1, 4'd3, 2'd2, 8'h21);
        for (int k = 0; k < 4; k++) do_msg("R5 toggle step", 8'h05 + 8'(k), 0, 0);

        // R6 off
        do_set("R6", 8'h00, 1, 4'd3, 2'd3, 8'h00);
        do_msg("R6 removed", 8'h05, 0, 0);
        do_set("R6 off absent", 8'h55, 0, 4'd4, 2'd3, 8'h00);

        // R7 overwrite and wildcard priority
        do_set("R7", 8'h9e, 0, 4'd10, 2'd1, 8'h01);
        do_set("R7", 8'h9e, 0, 4'd10, 2'd1, 8'h02);
        do_set("R7", 8'h00, 1, 4'd10, 2'd1, 8'h07);
        do_set("R7", 8'h9e, 0, 4'd12, 2'd1, 8'h33);
        do_msg("R7 specific wins", 8'h9e, 1, 0);
        do_msg("R7 wildcard only", 8'h01, 1, 0);

        // R8 clears
        do_set("R8", 8'h40, 0, 4'd1, 2'd1, 8'h66);
        do_write("R8 rx clear", 1, 8'h00, 0, 0, 0, 0, 2'd1, 0);
        do_msg("R8 rx gone", 8'h40, 0, 0);
        do_msg("R8 tx kept", 8'h9e, 1, 0);
        do_write("R8 op clear", 1, 8'h9e, 0, 0, 0, 0, 2'd2, 1);
        do_msg("R8 wildcard kept", 8'h9e, 1, 0);
        do_write("R8 all clear", 1, 8'h00, 0, 0, 0, 0, 2'd0, 0);
        do_msg("R8 all gone", 8'h9e, 1, 0);

        // R9 full
        for (int k = 0; k < NS; k++) do_set("R9 fill", 8'(k), 0, 4'd1, 2'd1, 8'(k + 1));
        do_set("R9 overflow", 8'h40, 0, 4'd1, 2'd1, 8'h99);
        check("R9 full set", 128'(tbl_full), 1);
        do_msg("R9 rejected rule", 8'h40, 0, 0);
        do_msg("R9 stored rule", 8'h0f, 0, 0);
        do_write("R9 clear resets full", 1, 8'h03, 0, 0, 0, 0, 2'd1, 1);
        do_set("R9 reuse", 8'h40, 0, 4'd1, 2'd1, 8'h99);
        do_msg("R9 reused slot", 8'h40, 0, 0);

        // R11 write during held
        do_write("R11 prep", 1, 8'h00, 0, 0, 0, 0, 2'd0, 0);
        do_msg("R11 inject", 8'h20, 0, 1);
        do_msg("R11 write ignored", 8'h77, 0, 0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r = $urandom_range(0, 9);
            bit [7:0] op = pool[$urandom_range(0, 3)];
            if (r < 5)
                do_set("R7 rnd set", op, ($urandom_range(0, 3) == 0), 4'($urandom_range(0, 15)),
                       2'($urandom_range(0, 3)), 8'($urandom));
            else if (r == 5)
                do_write("R8 rnd clear", 1, op, 0, 0, 0, 0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            else
                do_msg("R5 rnd msg", op, 1'($urandom_range(0, 1)), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule